// File: doc/BRIEF.md
# Asynchronous Serial Byte Receiver

This block recovers bytes from one asynchronous serial line that carries frames of one low start bit, a fixed number of data bits (eight by default) sent least significant bit first, and one high stop bit. Between frames the line rests high. The line first passes through a flip-flop chain that brings it into the local clock domain. A high-to-low step seen while idle opens a frame. A down-counter then waits half a bit period to reach the centre of the start bit, and after that one full period at a time, so that every bit is read at its centre.

When the stop bit has been read, the rebuilt byte is presented on the data output together with a one-clock strobe. A second one-clock flag in that same cycle reports a stop bit that was read low. The receiver is idle again in the cycle after the stop bit is read, so frames that follow each other with no gap are all received. The number of clock cycles per bit is an elaboration-time constant: 434 by default, which suits a 50 MHz clock at 115200 baud.

Top module: `serial_byte_rx`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `byte_o` is all zeros and `byte_valid_o` and `frame_err_o` are low. A frame that reset cut short yields no strobe.
- R2: While the line stays high, `byte_valid_o` stays low.
- R3: The first data bit received after the start bit lands in bit 0 of `byte_o`, and the last one lands in bit DATA_BITS-1.
- R4: Each bit is read CLKS_PER_BIT/2 cycles after the start of its period. A level change limited to the first two or last two cycles of a data bit does not change the byte received.
- R5: Take edge 0 as the first rising clock edge at which `serial_i` is low after idle. `byte_valid_o` then rises at rising edge SYNC_STAGES + CLKS_PER_BIT/2 + (DATA_BITS+1)*CLKS_PER_BIT.
- R6: A stop bit read low raises `frame_err_o` in the same cycle as `byte_valid_o`, and the byte is still delivered. A stop bit read high leaves `frame_err_o` low.
- R7: `byte_valid_o` is high for exactly one clock per frame. `byte_o` changes only in a cycle in which `byte_valid_o` is high.
- R8: A start bit that begins right at the end of the previous stop bit, with no idle time between them, is accepted.
- R9: If the line is high again at the centre of the start bit, the receiver returns to idle and gives no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| serial_i | input | 1 | Asynchronous serial line, idle high |
| byte_o | output | DATA_BITS | Last byte received |
| byte_valid_o | output | 1 | One-clock strobe: `byte_o` holds a new byte |
| frame_err_o | output | 1 | One-clock flag, set with the strobe when the stop bit was read low |

## Verification
The bench builds the receiver with 16 cycles per bit, eight data bits and a two-stage synchronizer. A frame then lasts only 160 cycles, so many frames fit in one short run. With these values the strobe is expected exactly 154 edges after the first low edge, and the centre of each bit lies eight cycles in. That leaves room to drive the opposite level during the first two and last two cycles of each data bit, which shows that only the centre is read. The default setting of 434 cycles per bit uses the same counter logic, only with a wider count.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_DATA  = 2'd2,
      RX_STOP  = 2'd3
   } rx_phase_e;

endpackage

// File: rtl/rx_line_sync.sv
// Brings the asynchronous line into the clock domain and flags high-to-low steps.
module rx_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic line_i,
   output logic line_o,
   output logic fall_o
);

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rx_line_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) chain_q[0] <= 1'b1;
      else     chain_q[0] <= line_i;
   end

   generate
      for (genvar g = 1; g < STAGES; g++) begin : g_stage
         always_ff @(posedge clk) begin
            if (rst) chain_q[g] <= 1'b1;
            else     chain_q[g] <= chain_q[g-1];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b1;
      else     prev_q <= chain_q[STAGES-1];
   end

   assign line_o = chain_q[STAGES-1];
   assign fall_o = prev_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/rx_bit_timer.sv
// Down-counter: load sets a start value, it then counts to zero and holds there.
module rx_bit_timer #(
   parameter int WIDTH = 9
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_i,
   input  logic [WIDTH-1:0] value_i,
   output logic [WIDTH-1:0] count_o,
   output logic             zero_o
);

   logic [WIDTH-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)                cnt_q <= '0;
      else if (load_i)        cnt_q <= value_i;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign count_o = cnt_q;
   assign zero_o  = (cnt_q == '0);

endmodule

// File: rtl/rx_shift_assembler.sv
// Shifts bits in from the top so that the first bit ends in bit 0.
module rx_shift_assembler #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             shift_i,
   input  logic             bit_i,
   output logic [WIDTH-1:0] word_o
);

   logic [WIDTH-1:0] word_q;

   generate
      if (WIDTH == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (rst)          word_q <= '0;
            else if (shift_i) word_q <= bit_i;
         end
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (rst)          word_q <= '0;
            else if (shift_i) word_q <= {bit_i, word_q[WIDTH-1:1]};
         end
      end
   endgenerate

   assign word_o = word_q;

endmodule

// File: rtl/serial_byte_rx.sv
module serial_byte_rx
   import serial_rx_pkg::*;
#(
   parameter int CLKS_PER_BIT = 434,
   parameter int DATA_BITS    = 8,
   parameter int SYNC_STAGES  = 2
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 serial_i,
   output logic [DATA_BITS-1:0] byte_o,
   output logic                 byte_valid_o,
   output logic                 frame_err_o
);

   localparam int CNT_W = $clog2(CLKS_PER_BIT);
   localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
   localparam logic [CNT_W-1:0] FULL_RELOAD = CNT_W'(CLKS_PER_BIT - 1);
   localparam logic [CNT_W-1:0] HALF_RELOAD = CNT_W'(CLKS_PER_BIT / 2 - 1);
   localparam logic [IDX_W-1:0] LAST_IDX    = IDX_W'(DATA_BITS - 1);

   generate
      if (CLKS_PER_BIT < 4) begin : g_bad_clks
         $error("serial_byte_rx: CLKS_PER_BIT must be at least 4");
      end
      if (DATA_BITS < 1) begin : g_bad_bits
         $error("serial_byte_rx: DATA_BITS must be at least 1");
      end
   endgenerate

   logic             line_s;
   logic             fall;
   logic             tick;
   logic [CNT_W-1:0] bit_count;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_value;
   logic             shift_en;
   logic [DATA_BITS-1:0] word;

   rx_phase_e        phase_q, phase_d;
   logic [IDX_W-1:0] idx_q;
   logic [DATA_BITS-1:0] byte_q;
   logic             valid_q;
   logic             ferr_q;
   logic             stop_read;

   rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst    (rst),
      .line_i (serial_i),
      .line_o (line_s),
      .fall_o (fall)
   );

   rx_bit_timer #(.WIDTH(CNT_W)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .load_i  (tmr_load),
      .value_i (tmr_value),
      .count_o (bit_count),
      .zero_o  (tick)
   );

   rx_shift_assembler #(.WIDTH(DATA_BITS)) u_asm (
      .clk     (clk),
      .rst     (rst),
      .shift_i (shift_en),
      .bit_i   (line_s),
      .word_o  (word)
   );

   always_comb begin
      phase_d   = phase_q;
      tmr_load  = 1'b0;
      tmr_value = FULL_RELOAD;
      shift_en  = 1'b0;
      unique case (phase_q)
         RX_IDLE: begin
            if (fall) begin
               phase_d   = RX_START;
               tmr_load  = 1'b1;
               tmr_value = HALF_RELOAD;
            end
         end
         RX_START: begin
            if (tick) begin
               if (!line_s) begin
                  phase_d  = RX_DATA;
                  tmr_load = 1'b1;
               end else begin
                  phase_d  = RX_IDLE;
               end
            end
         end
         RX_DATA: begin
            if (tick) begin
               shift_en = 1'b1;
               tmr_load = 1'b1;
               if (idx_q == LAST_IDX) phase_d = RX_STOP;
            end
         end
         RX_STOP: begin
            if (tick) phase_d = RX_IDLE;
         end
         default: phase_d = RX_IDLE;
      endcase
   end

   assign stop_read = (phase_q == RX_STOP) && tick;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= RX_IDLE;
         idx_q   <= '0;
         byte_q  <= '0;
         valid_q <= 1'b0;
         ferr_q  <= 1'b0;
      end else begin
         phase_q <= phase_d;
         valid_q <= stop_read;
         ferr_q  <= stop_read & ~line_s;
         if (stop_read) byte_q <= word;
         if (phase_q == RX_START) idx_q <= '0;
         else if (phase_q == RX_DATA && tick) idx_q <= idx_q + 1'b1;
      end
   end

   assign byte_o       = byte_q;
   assign byte_valid_o = valid_q;
   assign frame_err_o  = ferr_q;

endmodule

// File: rtl/serial_byte_rx_checker.sv
module serial_byte_rx_checker
   import serial_rx_pkg::*;
#(
   parameter int CLKS_PER_BIT = 434,
   parameter int DATA_BITS    = 8,
   parameter int CNT_W        = 9
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 line_s,
   input rx_phase_e            phase,
   input logic                 tick,
   input logic [CNT_W-1:0]     count,
   input logic [DATA_BITS-1:0] byte_o,
   input logic                 byte_valid_o,
   input logic                 frame_err_o
);

   assert_reset_quiet_R1: assert property (@(posedge clk)
      rst |=> (!byte_valid_o && !frame_err_o && byte_o == '0));

   assert_single_strobe_R7: assert property (@(posedge clk) disable iff (rst)
      byte_valid_o |=> !byte_valid_o);

   assert_byte_held_R7: assert property (@(posedge clk) disable iff (rst)
      !byte_valid_o |-> $stable(byte_o));

   assert_err_with_strobe_R6: assert property (@(posedge clk) disable iff (rst)
      frame_err_o |-> byte_valid_o);

   assert_idle_after_stop_R8: assert property (@(posedge clk) disable iff (rst)
      byte_valid_o |-> (phase == RX_IDLE || phase == RX_START));

   assert_count_range_R4: assert property (@(posedge clk) disable iff (rst)
      count <= CNT_W'(CLKS_PER_BIT - 1));

   assert_glitch_drop_R9: assert property (@(posedge clk) disable iff (rst)
      (phase == RX_START && tick && line_s) |=> (phase == RX_IDLE && !byte_valid_o));

endmodule

bind serial_byte_rx serial_byte_rx_checker #(
   .CLKS_PER_BIT (CLKS_PER_BIT),
   .DATA_BITS    (DATA_BITS),
   .CNT_W        (CNT_W)
) u_checker (
   .clk          (clk),
   .rst          (rst),
   .line_s       (line_s),
   .phase        (phase_q),
   .tick         (tick),
   .count        (bit_count),
   .byte_o       (byte_o),
   .byte_valid_o (byte_valid_o),
   .frame_err_o  (frame_err_o)
);

// File: tb/test_serial_byte_rx.sv
module test_serial_byte_rx;

   localparam int C    = 16;
   localparam int NB   = 8;
   localparam int SYNC = 2;
   localparam int NVEC = 8;
   // {stop level, data byte}
   localparam logic [8:0] VECS [NVEC] = '{
      9'h155, 9'h100, 9'h1FF, 9'h001, 9'h180, 9'h0A5, 9'h13C, 9'h0FF
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          serial_i = 1'b1;
   logic [NB-1:0] byte_o;
   logic          byte_valid_o;
   logic          frame_err_o;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   int strobes = 0;
   int run = 0;
   int max_run = 0;
   int last_cyc = 0;
   logic [NB-1:0] last_byte = '0;
   logic          last_err = 1'b0;
   bit            finished = 1'b0;

   always #10 clk = ~clk;

   serial_byte_rx #(
      .CLKS_PER_BIT (C),
      .DATA_BITS    (NB),
      .SYNC_STAGES  (SYNC)
   ) i_serial_byte_rx (
      .clk          (clk),
      .rst          (rst),
      .serial_i     (serial_i),
      .byte_o       (byte_o),
      .byte_valid_o (byte_valid_o),
      .frame_err_o  (frame_err_o)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (byte_valid_o) begin
         strobes   = strobes + 1;
         last_byte = byte_o;
         last_err  = frame_err_o;
         last_cyc  = cyc;
         run       = run + 1;
      end else begin
         run = 0;
      end
      if (run > max_run) max_run = run;
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic drive_for(logic val, int n);
      serial_i = val;
      repeat (n) @(negedge clk);
   endtask

   task automatic send_frame(logic [NB-1:0] d, logic stop, bit corrupt);
      drive_for(1'b0, C);
      for (int k = 0; k < NB; k++) begin
         if (corrupt) begin
            drive_for(!d[k], 2);
            drive_for(d[k], C - 4);
            drive_for(!d[k], 2);
         end else begin
            drive_for(d[k], C);
         end
      end
      drive_for(stop, C);
      serial_i = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int s0;
      int t0;
      repeat (4) @(negedge clk);
      // R1: state during reset
      check("R1 valid in reset", 32'(byte_valid_o), 0);
      check("R1 err in reset", 32'(frame_err_o), 0);
      check("R1 byte in reset", 32'(byte_o), 0);
      rst = 1'b0;
      @(negedge clk);
      check("R1 byte after release", 32'(byte_o), 0);

      // R2: idle line
      drive_for(1'b1, 5 * C);
      check("R2 no strobe while idle", 32'(strobes), 0);

      // R3 R6: vector table
      for (int i = 0; i < NVEC; i++) begin
         s0 = strobes;
         send_frame(VECS[i][7:0], VECS[i][8], 1'b0);
         drive_for(1'b1, C);
         check("R3 one strobe per frame", 32'(strobes - s0), 1);
         check("R3 byte LSB first", 32'(last_byte), 32'(VECS[i][7:0]));
         check("R6 framing flag", 32'(last_err), 32'(!VECS[i][8]));
      end

      // R7: single-cycle strobe and held byte
      check("R7 strobe width", 32'(max_run), 1);
      drive_for(1'b1, 3 * C);
      check("R7 byte held", 32'(byte_o), 32'(VECS[NVEC-1][7:0]));

      // R5: exact strobe latency
      t0 = cyc;
      send_frame(8'h3A, 1'b1, 1'b0);
      drive_for(1'b1, C);
      check("R5 strobe latency", 32'(last_cyc - t0), 32'(1 + SYNC + C / 2 + (NB + 1) * C));
      check("R5 byte", 32'(last_byte), 32'h3A);

      // R4: edge disturbances inside data bits
      send_frame(8'h96, 1'b1, 1'b1);
      drive_for(1'b1, C);
      check("R4 mid-bit sampling", 32'(last_byte), 32'h96);
      send_frame(8'h0F, 1'b1, 1'b1);
      drive_for(1'b1, C);
      check("R4 mid-bit sampling 2", 32'(last_byte), 32'h0F);

      // R8: back-to-back frames with no idle gap
      s0 = strobes;
      send_frame(8'hC3, 1'b1, 1'b0);
      send_frame(8'h5A, 1'b1, 1'b0);
      drive_for(1'b1, C);
      check("R8 both frames received", 32'(strobes - s0), 2);
      check("R8 second byte", 32'(last_byte), 32'h5A);

      // R9: short low glitch
      s0 = strobes;
      drive_for(1'b0, 4);
      drive_for(1'b1, 3 * C);
      check("R9 glitch gives no strobe", 32'(strobes - s0), 0);
      check("R9 byte unchanged", 32'(byte_o), 32'h5A);
      send_frame(8'h81, 1'b1, 1'b0);
      drive_for(1'b1, C);
      check("R9 frame after glitch", 32'(last_byte), 32'h81);

      // R1: reset in the middle of a frame
      s0 = strobes;
      drive_for(1'b0, C);
      drive_for(1'b1, 2 * C);
      rst = 1'b1;
      drive_for(1'b1, 3);
      check("R1 byte cleared", 32'(byte_o), 0);
      check("R1 valid low", 32'(byte_valid_o), 0);
      rst = 1'b0;
      drive_for(1'b1, 12 * C);
      check("R1 cut frame no strobe", 32'(strobes - s0), 0);
      send_frame(8'hE7, 1'b0, 1'b0);
      drive_for(1'b1, C);
      check("R1 works after reset", 32'(last_byte), 32'hE7);
      check("R6 error after reset", 32'(last_err), 1);
      check("R7 strobe width final", 32'(max_run), 1);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule